// File: doc/BRIEF.md
# Latched Interrupt Request Aggregator

This block collects interrupt events from eight groups of sources and presents them to a processor as one 8-bit request register and one active-low interrupt line. Each group owns an 8-bit status register, which records single-cycle event pulses arriving on the block's event port, and an 8-bit enable register, which selects the sources in that group that may raise the group's request bit. A request bit is set by a new event from an enabled source. It stays set until the processor reads that group's status register.

Reading a status register clears that register and the matching request bit. No write to the request register is needed, and none has any effect. Request bits are set only by event pulses and never by stored status levels. A source that has already been recorded therefore cannot bring the interrupt back after it has been serviced. The interrupt line stays low while any request bit is set. A service routine can therefore read the request register until it returns zero, which confirms that the line has been released. Access is through a simple synchronous register bus, and read data is returned on the cycle after the read strobe.

Top module: `intr_req_agg`

## Requirements
- R1: After reset all status, enable and request bits are zero, `irq_n` is 1 and `bus_rdata` is 0.
- R2: An event pulse on source s of group g sets status bit s of group g on the next clock edge, whatever the enable setting. The bit holds until a read of that group's status register.
- R3: An event pulse on a source whose enable bit is 1 sets request bit g on the next clock edge. Request bits 7 down to 0 belong to the receive alarm, second alarm, error, counter overflow, timer, data link 1, data link 2 and pattern groups.
- R4: An event on a source whose enable bit is 0 never sets a request bit.
- R5: A read of address 0x00B−g returns the status bits of group g as they stood before the read. The same read clears those status bits and request bit g on that clock edge.
- R6: If an event pulse arrives in the same cycle as a read that clears its group, the event's status bit survives the clear. If the source is enabled, request bit g also stays set.
- R7: Request bits are set only by event pulses. A status bit that is already set does not raise a request when its enable bit is later written to 1.
- R8: `irq_n` is 0 exactly when at least one request bit is set. It returns to 1 only after every set request bit has been cleared by a read of its group's status register.
- R9: A read of address 0x003 returns the request bits without changing them. Writes to 0x003 and to the status addresses have no effect.
- R10: The enable register of group g is read and written at address 0x013−g. A write loads all eight enable bits from `bus_wdata`. An event in the same cycle as that write is judged against the old enable value.
- R11: `bus_rdata` carries the addressed register on the cycle after a read strobe. It is 0 in any cycle that does not follow a read, and it is 0 after a read of an unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| evt_i | input | 64 | Event pulses; bits 8g+7..8g are the sources of group g |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The embedded properties check on every cycle that an enabled event sets its request bit and that any event sets its status bit. They also check that a clearing read with no coincident enabled event drops the request bit, that a clear request bit stays clear without an enabled event, and that the read data bus is zero after any cycle without a read. The bench's scenarios are the only way to show three behaviours. The first is that a source recorded while disabled stays silent after it is enabled. The second is that coincident events in several groups keep `irq_n` low until the last group is read. The third is that an event arriving together with its clearing read is preserved. The bench's cycle-by-cycle model also shows that writes to the read-only addresses leave every register unchanged.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Kind of register selected by the current bus address
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_REQ  = 2'd1,
        ACC_STAT = 2'd2,
        ACC_EN   = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_GROUPS = 8,
    parameter int REQ_ADDR   = 'h003,
    parameter int STAT_TOP   = 'h00B,
    parameter int EN_TOP     = 'h013,
    parameter int GIDX_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [GIDX_W-1:0] gidx
);

    // Group g: status at STAT_TOP-g, enable at EN_TOP-g
    always_comb begin
        kind = ACC_NONE;
        gidx = '0;
        if (addr == ADDR_W'(REQ_ADDR)) begin
            kind = ACC_REQ;
        end
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (addr == ADDR_W'(STAT_TOP - g)) begin
                kind = ACC_STAT;
                gidx = GIDX_W'(g);
            end
            if (addr == ADDR_W'(EN_TOP - g)) begin
                kind = ACC_EN;
                gidx = GIDX_W'(g);
            end
        end
    end

endmodule

// File: rtl/irq_agg_group.sv
module irq_agg_group #(
    parameter int SRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] evt_i,
    input  logic             rd_clr_i,
    input  logic             wr_en_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] stat_o,
    output logic [SRC_W-1:0] en_o,
    output logic             req_o
);

    typedef struct packed {
        logic [SRC_W-1:0] stat;
        logic [SRC_W-1:0] en;
        logic             req;
    } grp_state_t;

    grp_state_t st_d, st_q;
    logic       fresh;

    // Only pulses from enabled sources count; stored levels never do
    assign fresh = |(evt_i & st_q.en);

    always_comb begin
        st_d = st_q;
        if (rd_clr_i) begin
            st_d.stat = '0;
            st_d.req  = 1'b0;
        end
        st_d.stat = st_d.stat | evt_i;
        if (fresh) begin
            st_d.req = 1'b1;
        end
        if (wr_en_i) begin
            st_d.en = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign en_o   = st_q.en;
    assign req_o  = st_q.req;

    a_r2_event_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((st_q.stat & $past(evt_i)) == $past(evt_i)));

    a_r3_enabled_sets_req: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & st_q.en)) |=> st_q.req);

    a_r5_read_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && ((evt_i & st_q.en) == '0)) |=> !st_q.req);

    a_r7_no_spurious_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.req && ((evt_i & st_q.en) == '0)) |=> !st_q.req);

endmodule

// File: rtl/irq_agg_rdport.sv
module irq_agg_rdport
    import irq_agg_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int SRC_W      = 8,
    parameter int DATA_W     = 8,
    parameter int GIDX_W     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_i,
    input  acc_kind_e                   kind_i,
    input  logic [GIDX_W-1:0]           gidx_i,
    input  logic [NUM_GROUPS-1:0]       req_i,
    input  logic [NUM_GROUPS*SRC_W-1:0] stat_i,
    input  logic [NUM_GROUPS*SRC_W-1:0] en_i,
    output logic [DATA_W-1:0]           rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t rs_d, rs_q;

    // Unused upper bits read as zero
    always_comb begin
        rs_d.rdata = '0;
        if (rd_i) begin
            unique case (kind_i)
                ACC_REQ:  rs_d.rdata = DATA_W'(req_i);
                ACC_STAT: rs_d.rdata = DATA_W'(stat_i[gidx_i*SRC_W +: SRC_W]);
                ACC_EN:   rs_d.rdata = DATA_W'(en_i[gidx_i*SRC_W +: SRC_W]);
                default:  rs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign rdata_o = rs_q.rdata;

    a_r11_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> (rdata_o == '0));

endmodule

// File: rtl/intr_req_agg.sv
module intr_req_agg
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    parameter int NUM_GROUPS = 8,
    parameter int SRC_W      = 8,
    parameter int REQ_ADDR   = 'h003,
    parameter int STAT_TOP   = 'h00B,
    parameter int EN_TOP     = 'h013
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_GROUPS*SRC_W-1:0] evt_i,
    output logic                        irq_n
);

    localparam int GIDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

    acc_kind_e                   kind;
    logic [GIDX_W-1:0]           gidx;
    logic [NUM_GROUPS-1:0]       req;
    logic [NUM_GROUPS*SRC_W-1:0] stat_flat;
    logic [NUM_GROUPS*SRC_W-1:0] en_flat;

    irq_agg_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_GROUPS(NUM_GROUPS),
        .REQ_ADDR  (REQ_ADDR),
        .STAT_TOP  (STAT_TOP),
        .EN_TOP    (EN_TOP),
        .GIDX_W    (GIDX_W)
    ) u_decode (
        .addr(bus_addr),
        .kind(kind),
        .gidx(gidx)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic rd_clr;
        logic wr_en;
        assign rd_clr = bus_rd && (kind == ACC_STAT) && (gidx == GIDX_W'(g));
        assign wr_en  = bus_wr && (kind == ACC_EN) && (gidx == GIDX_W'(g));

        irq_agg_group #(
            .SRC_W(SRC_W)
        ) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_i[g*SRC_W +: SRC_W]),
            .rd_clr_i(rd_clr),
            .wr_en_i (wr_en),
            .wdata_i (bus_wdata[SRC_W-1:0]),
            .stat_o  (stat_flat[g*SRC_W +: SRC_W]),
            .en_o    (en_flat[g*SRC_W +: SRC_W]),
            .req_o   (req[g])
        );
    end

    irq_agg_rdport #(
        .NUM_GROUPS(NUM_GROUPS),
        .SRC_W     (SRC_W),
        .DATA_W    (DATA_W),
        .GIDX_W    (GIDX_W)
    ) u_rdport (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_i   (bus_rd),
        .kind_i (kind),
        .gidx_i (gidx),
        .req_i  (req),
        .stat_i (stat_flat),
        .en_i   (en_flat),
        .rdata_o(bus_rdata)
    );

    // Request bits come straight from flops; the line is their inverted OR
    assign irq_n = ~(|req);

endmodule

// File: tb/tb_intr_req_agg.sv
module tb_intr_req_agg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [63:0] evt_i = '0;
    logic        irq_n;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // Behavioural reference state
    logic [7:0] m_stat [8];
    logic [7:0] m_en [8];
    logic [7:0] m_req;
    logic [7:0] m_rdata;

    always #2 clk = ~clk;

    intr_req_agg dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_i(evt_i), .irq_n(irq_n)
    );

    always @(posedge clk) begin
        logic [7:0] nrd;
        logic [7:0] ev;
        if (!rst_n) begin
            for (int g = 0; g < 8; g++) begin
                m_stat[g] = 8'h00;
                m_en[g] = 8'h00;
            end
            m_req = 8'h00;
            m_rdata = 8'h00;
        end else begin
            nrd = 8'h00;
            if (bus_rd) begin
                if (bus_addr == 12'h003) nrd = m_req;
                for (int g = 0; g < 8; g++) begin
                    if (bus_addr == 12'(11 - g)) nrd = m_stat[g];
                    if (bus_addr == 12'(19 - g)) nrd = m_en[g];
                end
            end
            for (int g = 0; g < 8; g++) begin
                ev = evt_i[g*8 +: 8];
                if (bus_rd && bus_addr == 12'(11 - g)) begin
                    m_stat[g] = 8'h00;
                    m_req[g] = 1'b0;
                end
                m_stat[g] = m_stat[g] | ev;
                if ((ev & m_en[g]) != 8'h00) m_req[g] = 1'b1;
                if (bus_wr && bus_addr == 12'(19 - g)) m_en[g] = bus_wdata;
            end
            m_rdata = nrd;
        end
    end

    // Per-cycle comparison against the model (R8, R11)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (irq_n !== ~(|m_req)) begin
                fails++;
                $display("FAIL R8 model: irq_n=%0b expected %0b", irq_n, ~(|m_req));
            end
            vectors++;
            if (bus_rdata !== m_rdata) begin
                fails++;
                $display("FAIL R11 model: rdata=%02h expected %02h", bus_rdata, m_rdata);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [11:0] a, input logic rd, input logic wr,
                        input logic [7:0] wd, input logic [63:0] ev);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; evt_i = ev;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; evt_i = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        step(a, 1'b1, 1'b0, 8'h00, 64'h0);
        d = bus_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        step(a, 1'b0, 1'b1, d, 64'h0);
    endtask

    task automatic pulse(input logic [63:0] ev);
        step(12'h000, 1'b0, 1'b0, 8'h00, ev);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
        chk("R1 rdata", bus_rdata, 8'h00);
        rd(12'h003, d); chk("R1 req", d, 8'h00);
        rd(12'h00C, d); chk("R1 en7", d, 8'h00);

        // R10 enable readback at 0x013-g, R3 enabled event on group 7
        wr(12'h00C, 8'h01);
        rd(12'h00C, d); chk("R10 en7", d, 8'h01);
        pulse(64'h01 << 56);
        chk("R3 irq_n low", {7'b0, irq_n}, 8'h00);
        rd(12'h003, d); chk("R3 req bit7", d, 8'h80);
        rd(12'h003, d); chk("R9 req read no clear", d, 8'h80);

        // R9 write to request register ignored
        wr(12'h003, 8'h00);
        rd(12'h003, d); chk("R9 req write ignored", d, 8'h80);

        // R5 status read returns bits and clears request
        rd(12'h004, d); chk("R5 stat7", d, 8'h01);
        chk("R5 irq_n released", {7'b0, irq_n}, 8'h01);
        rd(12'h003, d); chk("R5 req cleared", d, 8'h00);
        rd(12'h004, d); chk("R5 stat7 cleared", d, 8'h00);

        // R4 disabled event records status but no request
        pulse(64'h08 << 16);
        chk("R4 irq_n", {7'b0, irq_n}, 8'h01);
        rd(12'h003, d); chk("R4 req", d, 8'h00);
        rd(12'h009, d); chk("R2 stat2", d, 8'h08);

        // R7 stored status level does not raise request when enabled
        pulse(64'h20 << 8);
        wr(12'h012, 8'h20);
        step(12'h000, 1'b0, 1'b0, 8'h00, 64'h0);
        chk("R7 irq_n", {7'b0, irq_n}, 8'h01);
        rd(12'h003, d); chk("R7 req", d, 8'h00);
        pulse(64'h20 << 8);
        rd(12'h003, d); chk("R7 fresh event", d, 8'h02);
        rd(12'h00A, d); chk("R7 stat1", d, 8'h20);

        // R9 write to a status address ignored
        pulse(64'h04 << 16);
        wr(12'h009, 8'hFF);
        rd(12'h009, d); chk("R9 stat write ignored", d, 8'h04);

        // R8 simultaneous events in groups 0, 3, 6
        wr(12'h013, 8'hFF);
        wr(12'h010, 8'hFF);
        wr(12'h00D, 8'hFF);
        pulse((64'h11 << 0) | (64'h22 << 24) | (64'h44 << 48));
        rd(12'h003, d); chk("R8 req multi", d, 8'h49);
        rd(12'h00B, d); chk("R8 stat0", d, 8'h11);
        chk("R8 low after one", {7'b0, irq_n}, 8'h00);
        rd(12'h008, d); chk("R8 stat3", d, 8'h22);
        chk("R8 low after two", {7'b0, irq_n}, 8'h00);
        rd(12'h005, d); chk("R8 stat6", d, 8'h44);
        chk("R8 high after all", {7'b0, irq_n}, 8'h01);
        rd(12'h003, d); chk("R8 req zero", d, 8'h00);

        // R6 event coincident with clearing read
        wr(12'h00F, 8'h03);
        pulse(64'h01 << 32);
        step(12'h007, 1'b1, 1'b0, 8'h00, 64'h02 << 32);
        chk("R6 read old stat4", bus_rdata, 8'h01);
        chk("R6 irq_n held", {7'b0, irq_n}, 8'h00);
        rd(12'h007, d); chk("R6 stat4 survives", d, 8'h02);
        rd(12'h003, d); chk("R6 req cleared later", d, 8'h00);

        // R10 same-cycle enable write and event uses old enable
        step(12'h00E, 1'b0, 1'b1, 8'h01, 64'h01 << 40);
        rd(12'h003, d); chk("R10 old enable used", d, 8'h00);
        rd(12'h00E, d); chk("R10 en5", d, 8'h01);

        // R11 unmapped read and idle cycle
        rd(12'h0FF, d); chk("R11 unmapped", d, 8'h00);
        @(negedge clk);
        chk("R11 idle", bus_rdata, 8'h00);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule